// File: doc/BRIEF.md
# Software Write-Protection Sequencer

This block sits between the qualified host write port of a paged non-volatile memory and its page write controller. Each host write either reaches the array through a one-cycle forward strobe or is held back. A page-load window opens on the first accepted write. The window stays open while each further write arrives no more than `LOAD_TO` cycles after the previous one. When the host goes quiet, the window closes and a programming period of `PROG_CYC` cycles follows. During that period `busy` is high and writes are dropped.

A persistent protection bit guards the array. Three address/data writes in a row set it, and a six-write sequence clears it. Both command sequences are parameters. Command writes are consumed and never reach the array. A new protection state takes effect only when the programming period that follows the sequence ends. While the bit is set, a data write reaches the array only when the enable sequence came first in the same load window. Without that sequence the data is dropped, but the window and the programming period still run, so the host sees `busy` as usual. A `power_cycle` input models a supply interruption: it discards any half-entered sequence, open window, programming period and pending change, and keeps the protection bit. Only `rst_n` restores the factory state, which is unprotected.

Top module: `wprot_seq`

## Requirements
- R1: After `rst_n` is asserted, `prot_on`, `busy` and `fwd_valid` are 0.
- R2: The default enable sequence is data 0xAA to 0x5555, data 0x55 to 0x2AAA, then data 0xA0 to 0x5555. None of those writes produces a `fwd_valid` pulse.
- R3: `prot_on` changes only in the cycle where a programming period ends. After an enable sequence it rises at that point and stays 0 throughout the `busy` period.
- R4: While protected, a data write that no enable sequence preceded in the same window is not forwarded. The window still closes into a `busy` period of normal length.
- R5: While protected, every data write that follows a completed enable sequence in the same window is forwarded.
- R6: The default disable sequence is six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. It is consumed, later data writes in its window are forwarded, and `prot_on` falls when the following programming period ends.
- R7: A write whose address or data differs from the next expected step ends the match. That write is handled as an ordinary data write, and matching restarts at step one with the next write.
- R8: A load window closes after `LOAD_TO` consecutive cycles without a write, which discards any partial sequence. A write exactly `LOAD_TO` cycles after the previous one still belongs to the same window.
- R9: Writes presented while `busy` is high have no effect: nothing is forwarded, and the matcher does not advance.
- R10: `power_cycle` clears the matcher, the open window, `busy` and any pending protection change. It leaves `prot_on` unchanged.
- R11: While unprotected, an ordinary write appears on `fwd_valid`/`fwd_addr`/`fwd_data` exactly one cycle later with the same address and data.
- R12: Once a window closes, `busy` stays high for exactly `PROG_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to factory state |
| power_cycle | input | 1 | Simulated supply interruption; keeps the protection bit |
| wr_valid | input | 1 | Qualified host write strobe, one cycle per write |
| wr_addr | input | AW | Host write address |
| wr_data | input | DW | Host write data |
| fwd_valid | output | 1 | Write forwarded to the page write controller |
| fwd_addr | output | AW | Forwarded address |
| fwd_data | output | DW | Forwarded data |
| busy | output | 1 | Programming period in progress |
| prot_on | output | 1 | Protection bit |

## Verification
The bench aims at the points where a sequencer that looks right in outline goes wrong:
- An enable sequence whose middle write mismatches. A design that restarts on the offending write, or keeps its place, would later let a blocked write through.
- Pauses exactly one cycle short of the timeout and past it. A design with an off-by-one window would merge or split loads wrongly.
- Writes that land during `busy`. A design that accepts them would forward data or advance the matcher.
- A `power_cycle` in the middle of a sequence and one during the programming period after a disable. A design that cleared too little would unlock the array; one that cleared too much would drop protection.
The per-cycle comparison also catches a protection bit that flips when the sequence completes instead of when the programming period ends.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_LOAD = 2'd1,
    WS_PROG = 2'd2
  } win_state_e;

  // bits needed to count 0 .. n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // protection may be bypassed when clear or when the window is unlocked
  function automatic logic may_pass(input logic prot, input logic unlocked);
    return !prot || unlocked;
  endfunction

endpackage

// File: rtl/swp_window.sv
module swp_window
  import swp_pkg::*;
#(
  parameter int unsigned LOAD_TO  = 8,
  parameter int unsigned PROG_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_cycle,
  input  logic wr_valid,
  output logic wr_acc,
  output logic win_close,
  output logic prog_done,
  output logic busy
);
  localparam int unsigned LW = cnt_w(LOAD_TO);
  localparam int unsigned PW = cnt_w(PROG_CYC);

  win_state_e    st_q;
  logic [LW-1:0] idle_q;
  logic [PW-1:0] prog_q;

  assign busy      = (st_q == WS_PROG);
  assign wr_acc    = wr_valid && !busy && !power_cycle;
  assign win_close = (st_q == WS_LOAD) && !wr_acc && !power_cycle &&
                     (idle_q == LW'(LOAD_TO - 1));
  assign prog_done = busy && !power_cycle && (prog_q == PW'(PROG_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      idle_q <= '0;
      prog_q <= '0;
    end else if (power_cycle) begin
      st_q   <= WS_IDLE;
      idle_q <= '0;
      prog_q <= '0;
    end else if (wr_acc) begin
      st_q   <= WS_LOAD;
      idle_q <= '0;
    end else if (win_close) begin
      st_q   <= WS_PROG;
      idle_q <= '0;
      prog_q <= '0;
    end else if (st_q == WS_LOAD) begin
      idle_q <= idle_q + 1'b1;
    end else if (prog_done) begin
      st_q   <= WS_IDLE;
      prog_q <= '0;
    end else if (busy) begin
      prog_q <= prog_q + 1'b1;
    end
  end

  // R8: a closing window always hands over to a programming period
  p_close_starts_busy_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> busy);

  // R12: busy ends only through its own completion or a power cycle
  p_busy_end_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(power_cycle)) |-> $past(prog_done));

  // R10: a power cycle always leaves the block idle
  p_pwr_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    power_cycle |=> !busy);

endmodule

// File: rtl/swp_matcher.sv
module swp_matcher #(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned EN_LEN  = 3,
  parameter int unsigned DIS_LEN = 6,
  parameter logic [EN_LEN*AW-1:0]  EN_ADDR  = {16'h5555, 16'h2AAA, 16'h5555},
  parameter logic [EN_LEN*DW-1:0]  EN_DATA  = {8'hA0, 8'h55, 8'hAA},
  parameter logic [DIS_LEN*AW-1:0] DIS_ADDR = {16'h5555, 16'h2AAA, 16'h5555,
                                               16'h5555, 16'h2AAA, 16'h5555},
  parameter logic [DIS_LEN*DW-1:0] DIS_DATA = {8'h20, 8'h55, 8'hAA,
                                               8'h80, 8'h55, 8'hAA}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_acc,
  input  logic          gate_off,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          cmd_hit,
  output logic          en_done,
  output logic          dis_done
);
  localparam int unsigned MAXL = (EN_LEN > DIS_LEN) ? EN_LEN : DIS_LEN;
  localparam int unsigned SW   = $clog2(MAXL + 1);

  logic [SW-1:0] step_q;
  logic          en_live_q, dis_live_q;
  logic [31:0]   k_cur;
  logic          en_hit, dis_hit;

  // step k of the enable sequence (slice k, step 0 in the low slice)
  function automatic logic en_step_eq(input int unsigned k,
                                      input logic [AW-1:0] a,
                                      input logic [DW-1:0] d);
    int unsigned j;
    j = k % EN_LEN;
    return (a == EN_ADDR[j*AW +: AW]) && (d == EN_DATA[j*DW +: DW]);
  endfunction

  function automatic logic dis_step_eq(input int unsigned k,
                                       input logic [AW-1:0] a,
                                       input logic [DW-1:0] d);
    int unsigned j;
    j = k % DIS_LEN;
    return (a == DIS_ADDR[j*AW +: AW]) && (d == DIS_DATA[j*DW +: DW]);
  endfunction

  assign k_cur = 32'(step_q);

  always_comb begin
    en_hit   = wr_acc && !gate_off && en_live_q && (k_cur < EN_LEN) &&
               en_step_eq(k_cur, addr, data);
    dis_hit  = wr_acc && !gate_off && dis_live_q && (k_cur < DIS_LEN) &&
               dis_step_eq(k_cur, addr, data);
    cmd_hit  = en_hit || dis_hit;
    en_done  = en_hit && (k_cur == EN_LEN - 1);
    dis_done = dis_hit && (k_cur == DIS_LEN - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q     <= '0;
      en_live_q  <= 1'b1;
      dis_live_q <= 1'b1;
    end else if (clear) begin
      step_q     <= '0;
      en_live_q  <= 1'b1;
      dis_live_q <= 1'b1;
    end else if (wr_acc && !gate_off) begin
      if (!cmd_hit || en_done || dis_done) begin
        step_q     <= '0;
        en_live_q  <= 1'b1;
        dis_live_q <= 1'b1;
      end else begin
        step_q     <= step_q + 1'b1;
        en_live_q  <= en_hit;
        dis_live_q <= dis_hit;
      end
    end
  end

  // R7: a write that breaks the sequence sends the matcher back to step one
  p_abort_restart_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !gate_off && !cmd_hit && !clear) |=> (step_q == '0));

  // R7: a partial match always has at least one candidate sequence alive
  p_live_partial_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != '0) |-> (en_live_q || dis_live_q));

  // R10: clearing always returns to step one
  p_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (step_q == '0));

endmodule

// File: rtl/swp_gate.sv
module swp_gate
  import swp_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          power_cycle,
  input  logic          wr_valid,
  input  logic          busy,
  input  logic          wr_acc,
  input  logic          cmd_hit,
  input  logic          en_done,
  input  logic          dis_done,
  input  logic          prog_done,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          unlocked,
  output logic          prot_on,
  output logic          fwd_valid,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data
);
  logic unl_q, pend_en_q, pend_dis_q, prot_q;
  logic data_wr, pass_now;

  assign data_wr  = wr_acc && !cmd_hit;
  assign pass_now = data_wr && may_pass(prot_q, unl_q);
  assign unlocked = unl_q;
  assign prot_on  = prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q      <= 1'b0;
      pend_en_q  <= 1'b0;
      pend_dis_q <= 1'b0;
      prot_q     <= 1'b0;
    end else if (power_cycle) begin
      unl_q      <= 1'b0;
      pend_en_q  <= 1'b0;
      pend_dis_q <= 1'b0;
    end else if (prog_done) begin
      if (pend_en_q)  prot_q <= 1'b1;
      if (pend_dis_q) prot_q <= 1'b0;
      unl_q      <= 1'b0;
      pend_en_q  <= 1'b0;
      pend_dis_q <= 1'b0;
    end else if (en_done) begin
      unl_q      <= 1'b1;
      pend_en_q  <= 1'b1;
      pend_dis_q <= 1'b0;
    end else if (dis_done) begin
      unl_q      <= 1'b1;
      pend_dis_q <= 1'b1;
      pend_en_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= pass_now;
      if (pass_now) begin
        fwd_addr <= addr;
        fwd_data <= data;
      end
    end
  end

  // R2, R6: command writes never reach the array
  p_cmd_swallowed_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && cmd_hit) |=> !fwd_valid);

  // R3: the protection bit moves only when a programming period completes
  p_prot_at_prog_end_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_q) |-> $past(prog_done));

  // R9: a write offered during busy yields nothing
  p_busy_drop_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> !fwd_valid);

  // R10: a power cycle leaves the protection bit where it was
  p_pwr_keeps_prot_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    power_cycle |=> $stable(prot_q));

  // R11: forwarded beats carry the address and data of the previous cycle
  p_fwd_echo_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_addr == $past(addr) && fwd_data == $past(data)));

endmodule

// File: rtl/wprot_seq.sv
module wprot_seq #(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned LOAD_TO  = 8,
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned EN_LEN   = 3,
  parameter int unsigned DIS_LEN  = 6,
  parameter logic [EN_LEN*AW-1:0]  EN_ADDR  = {16'h5555, 16'h2AAA, 16'h5555},
  parameter logic [EN_LEN*DW-1:0]  EN_DATA  = {8'hA0, 8'h55, 8'hAA},
  parameter logic [DIS_LEN*AW-1:0] DIS_ADDR = {16'h5555, 16'h2AAA, 16'h5555,
                                               16'h5555, 16'h2AAA, 16'h5555},
  parameter logic [DIS_LEN*DW-1:0] DIS_DATA = {8'h20, 8'h55, 8'hAA,
                                               8'h80, 8'h55, 8'hAA}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          power_cycle,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          fwd_valid,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data,
  output logic          busy,
  output logic          prot_on
);
  logic wr_acc, win_close, prog_done;
  logic cmd_hit, en_done, dis_done, unlocked;
  logic match_clear;

  assign match_clear = power_cycle || win_close;

  swp_window #(
    .LOAD_TO  (LOAD_TO),
    .PROG_CYC (PROG_CYC)
  ) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .power_cycle (power_cycle),
    .wr_valid    (wr_valid),
    .wr_acc      (wr_acc),
    .win_close   (win_close),
    .prog_done   (prog_done),
    .busy        (busy)
  );

  swp_matcher #(
    .AW       (AW),
    .DW       (DW),
    .EN_LEN   (EN_LEN),
    .DIS_LEN  (DIS_LEN),
    .EN_ADDR  (EN_ADDR),
    .EN_DATA  (EN_DATA),
    .DIS_ADDR (DIS_ADDR),
    .DIS_DATA (DIS_DATA)
  ) u_matcher (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (match_clear),
    .wr_acc   (wr_acc),
    .gate_off (unlocked),
    .addr     (wr_addr),
    .data     (wr_data),
    .cmd_hit  (cmd_hit),
    .en_done  (en_done),
    .dis_done (dis_done)
  );

  swp_gate #(
    .AW (AW),
    .DW (DW)
  ) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .power_cycle (power_cycle),
    .wr_valid    (wr_valid),
    .busy        (busy),
    .wr_acc      (wr_acc),
    .cmd_hit     (cmd_hit),
    .en_done     (en_done),
    .dis_done    (dis_done),
    .prog_done   (prog_done),
    .addr        (wr_addr),
    .data        (wr_data),
    .unlocked    (unlocked),
    .prot_on     (prot_on),
    .fwd_valid   (fwd_valid),
    .fwd_addr    (fwd_addr),
    .fwd_data    (fwd_data)
  );

endmodule

// File: tb/test_wprot_seq.sv
`timescale 1ns/1ps
module test_wprot_seq;
  localparam int LOAD_TO  = 8;
  localparam int PROG_CYC = 20;
  localparam int SETTLE   = LOAD_TO + PROG_CYC + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        power_cycle = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        fwd_valid, busy, prot_on;
  logic [15:0] fwd_addr;
  logic [7:0]  fwd_data;

  always #5 clk = ~clk;

  wprot_seq #(.LOAD_TO(LOAD_TO), .PROG_CYC(PROG_CYC)) i_wprot_seq (
    .clk(clk), .rst_n(rst_n), .power_cycle(power_cycle),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .busy(busy), .prot_on(prot_on)
  );

  int    n_vec = 0, n_bad = 0, fwd_seen = 0;
  bit    armed = 0, done = 0;
  string phase = "R1";

  // ---------------- behavioural reference ----------------
  int en_a[3]  = '{'h5555, 'h2AAA, 'h5555};
  int en_d[3]  = '{'hAA, 'h55, 'hA0};
  int dis_a[6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
  int dis_d[6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};

  int mode;        // 0 idle, 1 loading, 2 programming
  int quiet, prog_age, pos;
  bit en_ok, dis_ok, unl, want_on, want_off, m_prot;
  bit e_fv;
  int e_fa, e_fd;

  task automatic m_restart();
    pos = 0; en_ok = 1; dis_ok = 1;
  endtask

  always @(posedge clk) begin
    bit he, hd;
    if (!rst_n) begin
      mode = 0; quiet = 0; prog_age = 0; m_restart();
      unl = 0; want_on = 0; want_off = 0; m_prot = 0; e_fv = 0;
    end else if (power_cycle) begin
      mode = 0; quiet = 0; prog_age = 0; m_restart();
      unl = 0; want_on = 0; want_off = 0; e_fv = 0;
    end else begin
      e_fv = 0;
      if (mode == 2) begin
        prog_age++;
        if (prog_age == PROG_CYC) begin
          mode = 0;
          if (want_on) m_prot = 1;
          if (want_off) m_prot = 0;
          want_on = 0; want_off = 0; unl = 0;
        end
      end else if (wr_valid) begin
        mode = 1; quiet = 0;
        if (unl) begin
          e_fv = 1; e_fa = int'(wr_addr); e_fd = int'(wr_data);
        end else begin
          he = en_ok && pos < 3 && int'(wr_addr) == en_a[pos % 3] &&
               int'(wr_data) == en_d[pos % 3];
          hd = dis_ok && int'(wr_addr) == dis_a[pos] && int'(wr_data) == dis_d[pos];
          if (he && pos == 2) begin
            unl = 1; want_on = 1; want_off = 0; m_restart();
          end else if (hd && pos == 5) begin
            unl = 1; want_off = 1; want_on = 0; m_restart();
          end else if (he || hd) begin
            pos++; en_ok = he; dis_ok = hd;
          end else begin
            m_restart();
            if (!m_prot) begin
              e_fv = 1; e_fa = int'(wr_addr); e_fd = int'(wr_data);
            end
          end
        end
      end else if (mode == 1) begin
        quiet++;
        if (quiet == LOAD_TO) begin
          mode = 2; prog_age = 0; m_restart();
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && armed && !done) begin
      n_vec++;
      if (fwd_valid) fwd_seen++;
      if (fwd_valid !== e_fv || busy !== (mode == 2) || prot_on !== m_prot ||
          (e_fv && (int'(fwd_addr) != e_fa || int'(fwd_data) != e_fd))) begin
        n_bad++;
        $display("FAIL %s cycle compare: got fv=%0b a=%h d=%h busy=%0b prot=%0b, exp fv=%0b a=%h d=%h busy=%0b prot=%0b",
                 phase, fwd_valid, fwd_addr, fwd_data, busy, prot_on,
                 e_fv, e_fa[15:0], e_fd[7:0], mode == 2, m_prot);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_valid = 1'b1; wr_addr = 16'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pc();
    power_cycle = 1'b1;
    @(negedge clk);
    power_cycle = 1'b0;
  endtask

  task automatic en_seq();
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'hA0);
  endtask

  task automatic dis_seq();
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h80);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h20);
  endtask

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int base;
    int nb;
    idle(3);
    chk("R1 prot_on", int'(prot_on), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 fwd_valid", int'(fwd_valid), 0);
    rst_n = 1'b1;
    armed = 1;
    idle(1);

    phase = "R11"; base = fwd_seen;
    wr('h1234, 'h3C); wr('h1235, 'h3D); wr('h0000, 'hFF);
    idle(SETTLE);
    chk("R11 forwarded count", fwd_seen - base, 3);

    phase = "R2/R3"; base = fwd_seen;
    en_seq(); wr('h0100, 'h42);
    idle(LOAD_TO + 2);
    chk("R3 busy after enable", int'(busy), 1);
    chk("R3 prot still 0 while busy", int'(prot_on), 0);
    idle(SETTLE);
    chk("R2 commands swallowed", fwd_seen - base, 1);
    chk("R3 prot set after programming", int'(prot_on), 1);

    phase = "R4"; base = fwd_seen;
    wr('h0100, 'h99); wr('h5555, 'h12);
    idle(LOAD_TO + 1);
    chk("R4 blocked write still busy", int'(busy), 1);
    idle(SETTLE);
    chk("R4 nothing forwarded", fwd_seen - base, 0);

    phase = "R5"; base = fwd_seen;
    en_seq(); wr('h0200, 'h01); wr('h02FF, 'h02);
    idle(SETTLE);
    chk("R5 unlocked data forwarded", fwd_seen - base, 2);
    chk("R5 prot kept", int'(prot_on), 1);

    phase = "R7"; base = fwd_seen;
    wr('h5555, 'hAA); wr('h2AAA, 'h11); wr('h2AAA, 'h55); wr('h5555, 'hA0);
    wr('h0300, 'h07);
    idle(SETTLE);
    chk("R7 broken sequence unlocks nothing", fwd_seen - base, 0);

    phase = "R8"; base = fwd_seen;
    wr('h5555, 'hAA); wr('h2AAA, 'h55);
    idle(SETTLE);
    wr('h5555, 'hA0); wr('h0500, 'h03);
    idle(SETTLE);
    chk("R8 split sequence unlocks nothing", fwd_seen - base, 0);
    base = fwd_seen;
    wr('h5555, 'hAA); idle(LOAD_TO - 1);
    wr('h2AAA, 'h55); idle(LOAD_TO - 1);
    wr('h5555, 'hA0); idle(LOAD_TO - 1);
    wr('h0600, 'h04);
    idle(SETTLE);
    chk("R8 spacing at limit stays in window", fwd_seen - base, 1);

    phase = "R9"; base = fwd_seen;
    wr('h0700, 'h01);
    idle(LOAD_TO + 2);
    chk("R9 busy before late writes", int'(busy), 1);
    en_seq(); wr('h0701, 'h02);
    idle(SETTLE);
    wr('h0702, 'h03);
    idle(SETTLE);
    chk("R9 writes during busy ignored", fwd_seen - base, 0);

    phase = "R10"; base = fwd_seen;
    wr('h5555, 'hAA); wr('h2AAA, 'h55);
    pc();
    wr('h5555, 'hA0); wr('h0800, 'h09);
    idle(SETTLE);
    chk("R10 matcher cleared", fwd_seen - base, 0);
    chk("R10 prot kept", int'(prot_on), 1);
    base = fwd_seen;
    dis_seq(); wr('h0801, 'h05);
    idle(LOAD_TO + 3);
    pc();
    chk("R10 busy dropped", int'(busy), 0);
    idle(SETTLE);
    chk("R10 pending disable lost", int'(prot_on), 1);
    chk("R10 data before cycle forwarded", fwd_seen - base, 1);

    phase = "R6"; base = fwd_seen;
    dis_seq(); wr('h0900, 'h77);
    idle(LOAD_TO + 2);
    chk("R6 prot held during busy", int'(prot_on), 1);
    idle(SETTLE);
    chk("R6 disable swallowed, data forwarded", fwd_seen - base, 1);
    chk("R6 prot cleared", int'(prot_on), 0);

    phase = "R7"; base = fwd_seen;
    wr('h5555, 'hAA); wr('h0400, 'h05);
    idle(SETTLE);
    chk("R7 mismatching write ordinary", fwd_seen - base, 1);

    phase = "R12";
    wr('h0A00, 'h01);
    nb = 0;
    for (int i = 0; i < LOAD_TO + PROG_CYC + 10; i++) begin
      if (busy) nb++;
      @(negedge clk);
    end
    chk("R12 busy length", nb, PROG_CYC);

    summary();
  end

endmodule